// File: doc/BRIEF.md
# Sixteen-Bit Pulse Accumulator With Status Flags

This block counts activity on one input pin into a 16-bit accumulator. In event mode every active edge of the pin adds one to the count; in gated mode the pin acts as a gate, and the count advances once for every `tick_en` pulse seen while the gate is at its active level. `tick_en` stands in for a prescaled timer clock. Two sticky status flags record an input event and a count wrap. Each flag drives an interrupt request through its own enable.

A synchronous bus reaches the count and the flags through a two-bit byte address. The flag byte is at address 0 (bit 0 is the input-event flag, bit 1 is the wrap flag). Address 1 reads as zero. The count high byte is at address 2 and the low byte at address 3. With `bus_size16` high at address 2, one access moves the whole count as `{high, low}` on the 16-bit lanes. Byte accesses use lanes [7:0]. Reads are combinational in the cycle of the strobe.

The pin is synchronized through `SYNC_STAGES` flip-flops. A four-state controller then turns levels into count and event pulses. Its states are `ST_OFF` (accumulator disabled), `ST_EVENT` (edge counting), `ST_GATE_SHUT` (gated mode, gate inactive) and `ST_GATE_OPEN` (gated mode, gate active). When the accumulator enable is low, every state goes to `ST_OFF`. When it is high, any state goes to `ST_EVENT` if gated mode is off. In gated mode any state goes to `ST_GATE_OPEN` while the synchronized level is active and to `ST_GATE_SHUT` otherwise. The event pulse is produced on the transition from `ST_GATE_OPEN` to `ST_GATE_SHUT`, or on an active edge while in `ST_EVENT`.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset the count reads 0x0000, the flag byte reads 0x00 and both interrupt outputs are low.
- R2: In event mode with the accumulator enabled, each active edge adds one to the count. The active edge is rising when `cfg_active_hi`=1 and falling when it is 0.
- R3: In event mode an active edge sets the input-event flag (flag byte bit 0).
- R4: In gated mode the count adds one per `tick_en` pulse while the pin is at its active level (high when `cfg_active_hi`=1). Ticks while the gate is inactive are not counted.
- R5: In gated mode the trailing edge of the gate (leaving the active level) sets the input-event flag, and the leading edge does not.
- R6: A count step from 0xFFFF to 0x0000 sets the wrap flag (flag byte bit 1).
- R7: Writing a one to a flag bit at address 0 clears that flag only when `cfg_timer_en` or `cfg_acc_en` is high. Otherwise the write leaves the flag set.
- R8: With `cfg_fast_clr`=1, any read or write at address 2 or 3 clears both flags. With it at 0, such an access leaves the flags unchanged.
- R9: A word write at address 2 loads the full count. A byte write at address 2 or 3 replaces only that byte. Byte reads return the addressed byte on lanes [7:0].
- R10: A count write takes priority over a count step in the same cycle.
- R11: With `CH_PRESENT`=0 the count reads zero and writes to it have no effect.
- R12: `irq_edge` equals the input-event flag ANDed with `cfg_edge_irq_en`, and `irq_ovf` equals the wrap flag ANDed with `cfg_ovf_irq_en`.
- R13: While `cfg_acc_en`=0 the count does not change except by a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous input pin |
| tick_en | input | 1 | Prescaled tick for gated mode |
| cfg_timer_en | input | 1 | Timer enable (permits flag clear) |
| cfg_acc_en | input | 1 | Accumulator enable |
| cfg_gated | input | 1 | 1 = gated mode, 0 = event mode |
| cfg_active_hi | input | 1 | Active edge or gate level polarity |
| cfg_fast_clr | input | 1 | Count access clears all flags |
| cfg_edge_irq_en | input | 1 | Input-event interrupt enable |
| cfg_ovf_irq_en | input | 1 | Wrap interrupt enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size16 | input | 1 | Word access (honoured at address 2) |
| bus_addr | input | 2 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read |
| irq_edge | output | 1 | Input-event interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
The assertions assume the following about the inputs:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- `pin_in` holds each level for longer than the synchronizer depth plus one cycle, so no edge is lost.
- `tick_en` arrives as single-cycle pulses.
- Configuration bits change only while the pin is quiet.

The bench drives every input at the falling clock edge. It holds each pin level for four cycles and never overlaps the two strobes. It changes the mode bits only between scenarios, after the pin has settled.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd3;

    localparam int FLAG_EDGE_BIT = 0;
    localparam int FLAG_OVF_BIT  = 1;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_SHUT = 2'd2,
        ST_GATE_OPEN = 2'd3
    } pacc_state_e;
endpackage

// File: rtl/pacc_front.sv
module pacc_front
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic tick_en,
    input  logic acc_en,
    input  logic gated,
    input  logic active_hi,
    output logic count_pulse,
    output logic edge_pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;
    logic         lvl;
    logic         act_now;
    logic         act_prev;
    pacc_state_e  state_q;
    pacc_state_e  state_d;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[TOP-1:0], pin_in};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_in;
            end
        end
    endgenerate

    assign lvl = sync_q[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign act_now  = (lvl == active_hi);
    assign act_prev = (prev_q == active_hi);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        if (!acc_en)      state_d = ST_OFF;
        else if (!gated)  state_d = ST_EVENT;
        else if (act_now) state_d = ST_GATE_OPEN;
        else              state_d = ST_GATE_SHUT;
    end

    // Outputs
    always_comb begin
        count_pulse = 1'b0;
        edge_pulse  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                count_pulse = 1'b0;
                edge_pulse  = 1'b0;
            end
            ST_EVENT: begin
                edge_pulse  = acc_en && !gated && act_now && !act_prev;
                count_pulse = acc_en && !gated && act_now && !act_prev;
            end
            ST_GATE_SHUT: begin
                count_pulse = 1'b0;
                edge_pulse  = 1'b0;
            end
            ST_GATE_OPEN: begin
                count_pulse = acc_en && gated && tick_en;
                edge_pulse  = acc_en && gated && !act_now;
            end
            default: begin
                count_pulse = 1'b0;
                edge_pulse  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pacc_count.sv
module pacc_count #(
    parameter int BYTE_W     = 8,
    parameter int CH_PRESENT = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  ld_hi,
    input  logic                  ld_lo,
    input  logic [2*BYTE_W-1:0]   ld_data,
    output logic [2*BYTE_W-1:0]   cnt,
    output logic                  wrap
);
    localparam int CNT_W = 2 * BYTE_W;

    generate
        if (CH_PRESENT != 0) begin : g_present
            logic [CNT_W-1:0] cnt_q;
            logic             any_ld;

            assign any_ld = ld_hi || ld_lo;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (any_ld) begin
                    cnt_q <= {ld_hi ? ld_data[CNT_W-1:BYTE_W] : cnt_q[CNT_W-1:BYTE_W],
                              ld_lo ? ld_data[BYTE_W-1:0]     : cnt_q[BYTE_W-1:0]};
                end else if (step) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign cnt  = cnt_q;
            assign wrap = step && !any_ld && (&cnt_q);
        end else begin : g_absent
            assign cnt  = '0;
            assign wrap = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pacc_regs.sv
module pacc_regs
    import pacc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                timer_en,
    input  logic                acc_en,
    input  logic                fast_clr,
    input  logic                edge_irq_en,
    input  logic                ovf_irq_en,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                bus_size16,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*BYTE_W-1:0] bus_wdata,
    input  logic [2*BYTE_W-1:0] cnt,
    input  logic                edge_pulse,
    input  logic                wrap,
    output logic                ld_hi,
    output logic                ld_lo,
    output logic [2*BYTE_W-1:0] ld_data,
    output logic                flag_edge,
    output logic                flag_ovf,
    output logic [2*BYTE_W-1:0] rdata,
    output logic                irq_edge,
    output logic                irq_ovf
);
    localparam int CNT_W = 2 * BYTE_W;

    logic sel_flags, sel_hi, sel_lo, word;
    logic cnt_touch, w1c_ok, fast_hit;
    logic clr_edge, clr_ovf;
    logic flag_edge_q, flag_ovf_q;

    assign sel_flags = (bus_addr == ADDR_FLAGS);
    assign sel_hi    = (bus_addr == ADDR_CNT_HI);
    assign sel_lo    = (bus_addr == ADDR_CNT_LO);
    assign word      = bus_size16 && sel_hi;

    assign ld_hi   = bus_wr && sel_hi;
    assign ld_lo   = bus_wr && (sel_lo || word);
    assign ld_data = word ? bus_wdata : {bus_wdata[BYTE_W-1:0], bus_wdata[BYTE_W-1:0]};

    assign cnt_touch = (bus_rd || bus_wr) && (sel_hi || sel_lo);
    assign fast_hit  = fast_clr && cnt_touch;
    assign w1c_ok    = bus_wr && sel_flags && (timer_en || acc_en);
    assign clr_edge  = (w1c_ok && bus_wdata[FLAG_EDGE_BIT]) || fast_hit;
    assign clr_ovf   = (w1c_ok && bus_wdata[FLAG_OVF_BIT]) || fast_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_edge_q <= 1'b0;
            flag_ovf_q  <= 1'b0;
        end else begin
            if (edge_pulse)    flag_edge_q <= 1'b1;
            else if (clr_edge) flag_edge_q <= 1'b0;
            if (wrap)          flag_ovf_q  <= 1'b1;
            else if (clr_ovf)  flag_ovf_q  <= 1'b0;
        end
    end

    assign flag_edge = flag_edge_q;
    assign flag_ovf  = flag_ovf_q;
    assign irq_edge  = flag_edge_q && edge_irq_en;
    assign irq_ovf   = flag_ovf_q && ovf_irq_en;

    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            if (sel_flags) begin
                rdata[FLAG_EDGE_BIT] = flag_edge_q;
                rdata[FLAG_OVF_BIT]  = flag_ovf_q;
            end else if (word) begin
                rdata = cnt;
            end else if (sel_hi) begin
                rdata[BYTE_W-1:0] = cnt[CNT_W-1:BYTE_W];
            end else if (sel_lo) begin
                rdata[BYTE_W-1:0] = cnt[BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
    import pacc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CH_PRESENT  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_in,
    input  logic                tick_en,
    input  logic                cfg_timer_en,
    input  logic                cfg_acc_en,
    input  logic                cfg_gated,
    input  logic                cfg_active_hi,
    input  logic                cfg_fast_clr,
    input  logic                cfg_edge_irq_en,
    input  logic                cfg_ovf_irq_en,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                bus_size16,
    input  logic [1:0]          bus_addr,
    input  logic [2*BYTE_W-1:0] bus_wdata,
    output logic [2*BYTE_W-1:0] bus_rdata,
    output logic                irq_edge,
    output logic                irq_ovf
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             count_pulse;
    logic             edge_pulse;
    logic             wrap;
    logic             ld_hi, ld_lo;
    logic [CNT_W-1:0] ld_data;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_edge_q, flag_ovf_q;

    pacc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .tick_en     (tick_en),
        .acc_en      (cfg_acc_en),
        .gated       (cfg_gated),
        .active_hi   (cfg_active_hi),
        .count_pulse (count_pulse),
        .edge_pulse  (edge_pulse)
    );

    pacc_count #(.BYTE_W(BYTE_W), .CH_PRESENT(CH_PRESENT)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (count_pulse),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .ld_data (ld_data),
        .cnt     (cnt_q),
        .wrap    (wrap)
    );

    pacc_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_en    (cfg_timer_en),
        .acc_en      (cfg_acc_en),
        .fast_clr    (cfg_fast_clr),
        .edge_irq_en (cfg_edge_irq_en),
        .ovf_irq_en  (cfg_ovf_irq_en),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_size16  (bus_size16),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cnt         (cnt_q),
        .edge_pulse  (edge_pulse),
        .wrap        (wrap),
        .ld_hi       (ld_hi),
        .ld_lo       (ld_lo),
        .ld_data     (ld_data),
        .flag_edge   (flag_edge_q),
        .flag_ovf    (flag_ovf_q),
        .rdata       (bus_rdata),
        .irq_edge    (irq_edge),
        .irq_ovf     (irq_ovf)
    );
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk
    import pacc_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int CH_PRESENT = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_timer_en,
    input logic                cfg_acc_en,
    input logic                cfg_fast_clr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic                bus_size16,
    input logic [1:0]          bus_addr,
    input logic [2*BYTE_W-1:0] bus_wdata,
    input logic [2*BYTE_W-1:0] cnt_q,
    input logic                flag_edge_q,
    input logic                flag_ovf_q,
    input logic                edge_pulse
);
    logic cnt_sel, cnt_wr, cnt_acc, word_wr;

    assign cnt_sel = (bus_addr == ADDR_CNT_HI) || (bus_addr == ADDR_CNT_LO);
    assign cnt_wr  = bus_wr && cnt_sel;
    assign cnt_acc = (bus_rd || bus_wr) && cnt_sel;
    assign word_wr = bus_wr && bus_size16 && (bus_addr == ADDR_CNT_HI);

    // R3
    a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> flag_edge_q);

    // R6
    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && !cnt_wr) |=> (cnt_q != '0 || flag_ovf_q));

    // R7
    a_r7_no_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_edge_q && !cfg_timer_en && !cfg_acc_en && !(cfg_fast_clr && cnt_acc))
        |=> flag_edge_q);

    // R8
    a_r8_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fast_clr && cnt_acc && !edge_pulse) |=> !flag_edge_q);

    // R10
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (CH_PRESENT != 0 && word_wr) |=> (cnt_q == $past(bus_wdata)));

    // R13
    a_r13_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_acc_en && !cnt_wr) |=> $stable(cnt_q));
endmodule

bind pulse_acc_top pacc_chk #(.BYTE_W(BYTE_W), .CH_PRESENT(CH_PRESENT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_timer_en (cfg_timer_en),
    .cfg_acc_en   (cfg_acc_en),
    .cfg_fast_clr (cfg_fast_clr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_size16   (bus_size16),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .cnt_q        (cnt_q),
    .flag_edge_q  (flag_edge_q),
    .flag_ovf_q   (flag_ovf_q),
    .edge_pulse   (edge_pulse)
);

// File: tb/pulse_acc_top_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        tick_en = 1'b0;
    logic        cfg_timer_en = 1'b0;
    logic        cfg_acc_en = 1'b0;
    logic        cfg_gated = 1'b0;
    logic        cfg_active_hi = 1'b1;
    logic        cfg_fast_clr = 1'b0;
    logic        cfg_edge_irq_en = 1'b0;
    logic        cfg_ovf_irq_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_size16 = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata, abs_rdata;
    logic        irq_edge, irq_ovf, abs_irq_edge, abs_irq_ovf;

    int checks = 0;
    int failures = 0;
    logic [15:0] rd_val, rd_abs;

    always #2.5 clk = ~clk;

    pulse_acc_top dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick_en(tick_en),
        .cfg_timer_en(cfg_timer_en), .cfg_acc_en(cfg_acc_en), .cfg_gated(cfg_gated),
        .cfg_active_hi(cfg_active_hi), .cfg_fast_clr(cfg_fast_clr),
        .cfg_edge_irq_en(cfg_edge_irq_en), .cfg_ovf_irq_en(cfg_ovf_irq_en),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size16(bus_size16), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_edge(irq_edge), .irq_ovf(irq_ovf)
    );

    pulse_acc_top #(.CH_PRESENT(0)) dut_abs (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick_en(tick_en),
        .cfg_timer_en(cfg_timer_en), .cfg_acc_en(cfg_acc_en), .cfg_gated(cfg_gated),
        .cfg_active_hi(cfg_active_hi), .cfg_fast_clr(cfg_fast_clr),
        .cfg_edge_irq_en(cfg_edge_irq_en), .cfg_ovf_irq_en(cfg_ovf_irq_en),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size16(bus_size16), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(abs_rdata), .irq_edge(abs_irq_edge), .irq_ovf(abs_irq_ovf)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size16 = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_size16 = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic w);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size16 = w;
        #1;
        rd_val = bus_rdata;
        rd_abs = abs_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_size16 = 1'b0;
    endtask

    // one full high-then-low cycle on the pin
    task automatic pin_pulse();
        pin_in = 1'b1; cyc(4);
        pin_in = 1'b0; cyc(4);
    endtask

    task automatic t_reset();
        bus_read(2'd2, 1'b1); chk("R1 count", rd_val, 16'h0000);
        bus_read(2'd0, 1'b0); chk("R1 flags", rd_val, 16'h0000);
        cfg_edge_irq_en = 1'b1; cfg_ovf_irq_en = 1'b1; #1;
        chk("R1 irqs", {14'h0, irq_edge, irq_ovf}, 16'h0000);
        cfg_edge_irq_en = 1'b0; cfg_ovf_irq_en = 1'b0;
    endtask

    task automatic t_event_rise();
        cfg_acc_en = 1'b1; cfg_gated = 1'b0; cfg_active_hi = 1'b1; cyc(4);
        repeat (3) pin_pulse();
        bus_read(2'd2, 1'b1); chk("R2 rising count", rd_val, 16'd3);
        bus_read(2'd0, 1'b0); chk("R3 edge flag set", rd_val, 16'h0001);
        bus_write(2'd0, 1'b0, 16'h0001);
        bus_read(2'd0, 1'b0); chk("R7 w1c with acc_en", rd_val, 16'h0000);
    endtask

    task automatic t_event_fall();
        cfg_active_hi = 1'b0; cyc(4);
        bus_write(2'd2, 1'b1, 16'h0000);
        repeat (2) pin_pulse();
        bus_read(2'd2, 1'b1); chk("R2 falling count", rd_val, 16'd2);
        bus_write(2'd0, 1'b0, 16'h0001);
    endtask

    task automatic t_disabled();
        pin_pulse();
        cfg_acc_en = 1'b0; cfg_timer_en = 1'b0; cyc(2);
        repeat (2) pin_pulse();
        bus_read(2'd2, 1'b1); chk("R13 hold when off", rd_val, 16'd3);
        bus_write(2'd0, 1'b0, 16'h0001);
        bus_read(2'd0, 1'b0); chk("R7 w1c ignored", rd_val, 16'h0001);
        cfg_timer_en = 1'b1; cyc(1);
        bus_write(2'd0, 1'b0, 16'h0001);
        bus_read(2'd0, 1'b0); chk("R7 w1c with timer_en", rd_val, 16'h0000);
    endtask

    task automatic t_gated();
        cfg_acc_en = 1'b1; cfg_gated = 1'b1; cfg_active_hi = 1'b1; cyc(4);
        bus_write(2'd2, 1'b1, 16'h0000);
        pin_in = 1'b1; cyc(4);
        bus_read(2'd0, 1'b0); chk("R5 leading edge no flag", rd_val, 16'h0000);
        repeat (5) begin
            tick_en = 1'b1; @(negedge clk); tick_en = 1'b0; @(negedge clk);
        end
        bus_read(2'd2, 1'b1); chk("R4 gated ticks", rd_val, 16'd5);
        pin_in = 1'b0; cyc(4);
        bus_read(2'd0, 1'b0); chk("R5 trailing edge flag", rd_val, 16'h0001);
        repeat (3) begin
            tick_en = 1'b1; @(negedge clk); tick_en = 1'b0; @(negedge clk);
        end
        bus_read(2'd2, 1'b1); chk("R4 closed gate ignores ticks", rd_val, 16'd5);
        bus_write(2'd0, 1'b0, 16'h0001);
    endtask

    task automatic t_priority();
        pin_in = 1'b1; cyc(4);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_size16 = 1'b1; bus_wdata = 16'h1234;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0; bus_rd = 1'b1;
        #1; chk("R10 write beats step", bus_rdata, 16'h1234);
        @(negedge clk);
        bus_rd = 1'b0; bus_size16 = 1'b0;
        pin_in = 1'b0; cyc(4);
        bus_write(2'd0, 1'b0, 16'h0001);
    endtask

    task automatic t_bytes();
        bus_write(2'd2, 1'b1, 16'hABCD);
        bus_write(2'd2, 1'b0, 16'h0012);
        bus_read(2'd2, 1'b1); chk("R9 byte write high", rd_val, 16'h12CD);
        bus_write(2'd3, 1'b0, 16'h0034);
        bus_read(2'd2, 1'b1); chk("R9 byte write low", rd_val, 16'h1234);
        bus_read(2'd2, 1'b0); chk("R9 byte read high", rd_val, 16'h0012);
        bus_read(2'd3, 1'b0); chk("R9 byte read low", rd_val, 16'h0034);
    endtask

    task automatic t_overflow();
        cfg_gated = 1'b0; cfg_active_hi = 1'b1; cyc(4);
        bus_write(2'd2, 1'b1, 16'hFFFE);
        pin_pulse();
        bus_read(2'd0, 1'b0); chk("R6 no wrap at FFFF", rd_val, 16'h0001);
        pin_pulse();
        bus_read(2'd2, 1'b1); chk("R6 count wrapped", rd_val, 16'h0000);
        bus_read(2'd0, 1'b0); chk("R6 wrap flag", rd_val, 16'h0003);
        cfg_edge_irq_en = 1'b1; cfg_ovf_irq_en = 1'b1; #1;
        chk("R12 irqs enabled", {14'h0, irq_edge, irq_ovf}, 16'h0003);
        cfg_ovf_irq_en = 1'b0; #1;
        chk("R12 ovf irq masked", {14'h0, irq_edge, irq_ovf}, 16'h0002);
        cfg_ovf_irq_en = 1'b1;
        bus_write(2'd0, 1'b0, 16'h0003);
        bus_read(2'd0, 1'b0); chk("R7 both cleared", rd_val, 16'h0000);
        chk("R12 irqs follow clear", {14'h0, irq_edge, irq_ovf}, 16'h0000);
        cfg_edge_irq_en = 1'b0; cfg_ovf_irq_en = 1'b0;
    endtask

    task automatic t_fast();
        cfg_fast_clr = 1'b1;
        pin_pulse();
        bus_read(2'd0, 1'b0); chk("R8 flag read keeps flag", rd_val, 16'h0001);
        bus_read(2'd3, 1'b0);
        bus_read(2'd0, 1'b0); chk("R8 count read clears", rd_val, 16'h0000);
        pin_pulse();
        bus_write(2'd2, 1'b0, 16'h0000);
        bus_read(2'd0, 1'b0); chk("R8 count write clears", rd_val, 16'h0000);
        cfg_fast_clr = 1'b0;
        pin_pulse();
        bus_read(2'd2, 1'b1);
        bus_read(2'd0, 1'b0); chk("R8 off keeps flag", rd_val, 16'h0001);
        bus_write(2'd0, 1'b0, 16'h0001);
    endtask

    task automatic t_absent();
        bus_write(2'd2, 1'b1, 16'h5555);
        bus_read(2'd2, 1'b1);
        chk("R9 word write present", rd_val, 16'h5555);
        chk("R11 absent word read", rd_abs, 16'h0000);
        pin_pulse();
        bus_read(2'd3, 1'b0);
        chk("R2 present counts", rd_val, 16'h0056);
        chk("R11 absent stays zero", rd_abs, 16'h0000);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_event_rise();
        t_event_fall();
        t_disabled();
        t_gated();
        t_priority();
        t_bytes();
        t_overflow();
        t_fast();
        t_absent();
        cyc(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule